// File: doc/BRIEF.md
# Three-Source Interrupt Controller

This block gathers three interrupt causes for a small 8-bit processor core and turns them into a single request line and a fixed vector. The first cause is an edge on bit 0 of an 8-bit input port; its polarity comes from a select input that another register owns. The second is an overflow pulse from a timer. The third is a change on the upper four port bits, measured against a snapshot of those bits.

Each cause sets a sticky flag in one 8-bit status/enable register. Each flag has its own enable, and a global enable gates all of them. Software reads and writes the register through a plain write strobe and a read-data bus. The core reports that it has taken the interrupt with an acknowledge strobe, which clears the global enable. A return strobe sets the global enable again. The program counter, stack and instruction decode belong to the core; this block only raises the request and supplies the vector.

Top module: `irq_ctl`

## Requirements
- R1: One clock edge with `rst` high clears every status bit to 0. The same edge loads the edge detector's previous-pin state and the change snapshot from the live port, so leaving reset creates no spurious event.
- R2: Status layout. Bit 0 is the port-change flag, bit 1 the external flag and bit 2 the timer flag. Bits 3, 4 and 5 are the matching enables, in that order. Bit 7 is the global enable. Bit 6 always reads 0, whatever is written to it.
- R3: A `tmr_ovf` high at a clock edge makes status bit 2 read 1 after that edge.
- R4: With `edge_rise` = 0, a 1-to-0 change of `port_in[0]` between two clock edges sets status bit 1 at the second edge. A 0-to-1 change does not set it.
- R5: With `edge_rise` = 1, a 0-to-1 change of `port_in[0]` sets status bit 1. A 1-to-0 change does not set it.
- R6: At every clock edge where `port_in[7:4]` differs from the snapshot, status bit 0 is set. Bits 3:0 of the port never set it.
- R7: A `port_rd` high at a clock edge loads `port_in[7:4]` into the snapshot. The comparison at that same edge still uses the old snapshot.
- R8: A flag stays 1 until a write puts 0 in its bit. If a hardware event for a flag occurs in the same cycle as a write of 0 to it, the flag ends up 1.
- R9: `irq_req` is 1 exactly when bit 7 is 1 and at least one flag is 1 together with its own enable.
- R10: `irq_ack` high at an edge clears bit 7. It wins over `irq_ret` and over a write in the same cycle.
- R11: `irq_ret` high at an edge, without `irq_ack`, sets bit 7. It wins over a write in the same cycle.
- R12: `irq_vec` always equals 0x004.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the status/enable register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Current register value |
| port_in | input | 8 | Live port pins |
| port_rd | input | 1 | Port read strobe; reloads the change snapshot |
| edge_rise | input | 1 | External edge select: 0 falling, 1 rising |
| tmr_ovf | input | 1 | Timer overflow pulse |
| irq_ack | input | 1 | Interrupt entry strobe from the core |
| irq_ret | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 10 | Vector address |

## Verification
Directed sequences cover four separate concerns:
- Both edge polarities, each driven with the wrong edge as well, to show that the select input really flips which edge counts.
- Toggles on the lower port bits against toggles on the upper bits, to separate the watched nibble from the rest of the port.
- A port read during a mismatch, followed by a clear, to show that the snapshot reload is what ends the change condition.
- Same-cycle collisions: an event against a clear, acknowledge against return, and return against a write. These pin down the priority order.

A long random run then drives every input freely each cycle. It compares the register and the request against a cycle model, which exposes wrong enable pairing and gating that only shows up when the inputs combine.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int REG_W = 8;
    localparam int NSRC  = 3;

    // source indices inside flag and enable fields
    localparam int SRC_PCHG = 0;
    localparam int SRC_EXT  = 1;
    localparam int SRC_TMR  = 2;

    typedef struct packed {
        logic            gie;
        logic            rsv;
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] flg;
    } stat_t;

    localparam stat_t STAT_RST = '0;

    function automatic logic pending(input stat_t s);
        return s.gie && |(s.flg & s.en);
    endfunction

    function automatic stat_t to_stat(input logic [REG_W-1:0] v);
        stat_t s;
        s     = stat_t'(v);
        s.rsv = 1'b0;
        return s;
    endfunction

endpackage

// File: rtl/irq_ext_edge.sv
module irq_ext_edge (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic rise_sel,
    output logic hit
);
    logic prev_q;

    always_ff @(posedge clk) begin
        prev_q <= pin;
    end

    always_comb begin
        if (rst)           hit = 1'b0;
        else if (rise_sel) hit = pin & ~prev_q;
        else               hit = prev_q & ~pin;
    end
endmodule

// File: rtl/irq_port_watch.sv
module irq_port_watch #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] watch,
    input  logic         resync,
    output logic         hit
);
    logic [W-1:0] snap_q;

    always_ff @(posedge clk) begin
        if (rst || resync) snap_q <= watch;
    end

    assign hit = !rst && (watch != snap_q);
endmodule

// File: rtl/irq_stat_reg.sv
module irq_stat_reg
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic [NSRC-1:0]  src_hit,
    input  logic             ack,
    input  logic             ret,
    output stat_t            stat
);
    stat_t stat_q, base, nxt;

    always_comb begin
        base    = wr ? to_stat(wdata) : stat_q;
        nxt     = base;
        nxt.rsv = 1'b0;
        nxt.flg = base.flg | src_hit;
        if (ack)      nxt.gie = 1'b0;
        else if (ret) nxt.gie = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= STAT_RST;
        else     stat_q <= nxt;
    end

    assign stat = stat_q;
endmodule

// File: rtl/irq_ctl.sv
module irq_ctl
    import irq_pkg::*;
#(
    parameter int          PORT_W   = 8,
    parameter int          WATCH_LO = 4,
    parameter int          VEC_W    = 10,
    parameter logic [9:0]  VEC_ADDR = 10'h004
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [PORT_W-1:0] port_in,
    input  logic              port_rd,
    input  logic              edge_rise,
    input  logic              tmr_ovf,
    input  logic              irq_ack,
    input  logic              irq_ret,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vec
);
    localparam int WATCH_W = PORT_W - WATCH_LO;

    logic [NSRC-1:0] src_hit;
    stat_t           stat;

    irq_ext_edge u_ext (
        .clk      (clk),
        .rst      (rst),
        .pin      (port_in[0]),
        .rise_sel (edge_rise),
        .hit      (src_hit[SRC_EXT])
    );

    irq_port_watch #(.W(WATCH_W)) u_watch (
        .clk    (clk),
        .rst    (rst),
        .watch  (port_in[PORT_W-1:WATCH_LO]),
        .resync (port_rd),
        .hit    (src_hit[SRC_PCHG])
    );

    assign src_hit[SRC_TMR] = tmr_ovf & ~rst;

    irq_stat_reg u_stat (
        .clk     (clk),
        .rst     (rst),
        .wr      (reg_wr),
        .wdata   (reg_wdata),
        .src_hit (src_hit),
        .ack     (irq_ack),
        .ret     (irq_ret),
        .stat    (stat)
    );

    assign reg_rdata = stat;
    assign irq_req   = pending(stat);
    assign irq_vec   = VEC_W'(VEC_ADDR);
endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk (
    input logic       clk,
    input logic       rst,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       tmr_ovf,
    input logic       irq_ack,
    input logic       irq_ret,
    input logic       irq_req
);
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[6] == 1'b0);  // R2
    AST_TMR_SET: assert property (@(posedge clk) disable iff (rst)
        tmr_ovf |=> reg_rdata[2]);  // R3
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[2] && !reg_wr) |=> reg_rdata[2]);  // R8
    AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> reg_rdata[7]);  // R9
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> !reg_rdata[7] && !irq_req);  // R10
    AST_RET_SETS: assert property (@(posedge clk) disable iff (rst)
        (irq_ret && !irq_ack) |=> reg_rdata[7]);  // R11
endmodule

bind irq_ctl irq_ctl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .tmr_ovf   (tmr_ovf),
    .irq_ack   (irq_ack),
    .irq_ret   (irq_ret),
    .irq_req   (irq_req)
);

// File: tb/sim_irq_ctl.sv
module sim_irq_ctl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] port_in = '0;
    logic       port_rd = 1'b0;
    logic       edge_rise = 1'b0;
    logic       tmr_ovf = 1'b0;
    logic       irq_ack = 1'b0;
    logic       irq_ret = 1'b0;
    logic       irq_req;
    logic [9:0] irq_vec;

    int n_chk = 0;
    int n_bad = 0;

    // bench model state
    logic [7:0] m_stat;
    logic       m_prev;
    logic [3:0] m_snap;

    always #10 clk = ~clk;

    irq_ctl u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .port_in(port_in), .port_rd(port_rd),
        .edge_rise(edge_rise), .tmr_ovf(tmr_ovf), .irq_ack(irq_ack),
        .irq_ret(irq_ret), .irq_req(irq_req), .irq_vec(irq_vec)
    );

    function automatic logic exp_req(input logic [7:0] s);
        return s[7] && |(s[2:0] & s[5:3]);
    endfunction

    function automatic logic [7:0] exp_next(input logic [7:0] s);
        logic [7:0] b;
        logic ext_ev;
        b = reg_wr ? reg_wdata : s;
        b[6] = 1'b0;
        ext_ev = edge_rise ? (port_in[0] & ~m_prev) : (m_prev & ~port_in[0]);
        b[2] = b[2] | tmr_ovf;
        b[1] = b[1] | ext_ev;
        b[0] = b[0] | (port_in[7:4] != m_snap);
        if (irq_ack)      b[7] = 1'b0;
        else if (irq_ret) b[7] = 1'b1;
        return b;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // inputs are already driven (after a negedge); advance one edge and compare
    task automatic step(input string tag);
        logic [7:0] nx;
        nx = exp_next(m_stat);
        @(posedge clk);
        m_stat = nx;
        m_prev = port_in[0];
        if (port_rd) m_snap = port_in[7:4];
        #2;
        chk(tag, {23'd0, irq_req, reg_rdata}, {23'd0, exp_req(m_stat), m_stat});
        @(negedge clk);
        reg_wr = 0; port_rd = 0; tmr_ovf = 0; irq_ack = 0; irq_ret = 0;
    endtask

    task automatic wr(input logic [7:0] v, input string tag);
        reg_wr = 1; reg_wdata = v;
        step(tag);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        port_in = 8'h5A;
        @(negedge clk);
        reg_wdata = 8'hFF;
        @(posedge clk); #2;
        chk("R1 reset", {24'd0, reg_rdata}, 32'h00);
        chk("R12 vector", {22'd0, irq_vec}, 32'h004);
        @(negedge clk);
        rst = 0;
        m_stat = 8'h00; m_prev = port_in[0]; m_snap = port_in[7:4];
        step("R1 no event after reset");

        // R2: bit 6 write ignored, layout
        wr(8'h78, "R2 write bit6 and enables");
        wr(8'h00, "R2 clear");

        // R3 timer
        tmr_ovf = 1; step("R3 timer flag");
        wr(8'h00, "R8 clear timer");

        // R4 falling
        edge_rise = 0; port_in[0] = 1'b1; step("R4 rising ignored");
        port_in[0] = 1'b0; step("R4 falling sets");
        wr(8'h00, "R8 clear ext");
        // R5 rising
        edge_rise = 1; port_in[0] = 1'b1; step("R5 rising sets");
        wr(8'h00, "R8 clear");
        port_in[0] = 1'b0; step("R5 falling ignored");

        // R6 low nibble ignored, high nibble detected
        port_in[3:1] = ~port_in[3:1]; step("R6 low bits ignored");
        port_in[7] = ~port_in[7]; step("R6 upper change sets");
        // R8 clear while mismatch persists: event wins
        wr(8'h00, "R8 event beats clear");
        // R7 port read resyncs, old snapshot still compared that edge
        port_rd = 1; step("R7 read resyncs");
        wr(8'h00, "R7 clear after resync");
        step("R7 stays clear");

        // R9 request gating
        tmr_ovf = 1; step("R9 flag only");
        wr(8'h24, "R9 flag+enable no gie");
        wr(8'hA4, "R9 request raised");
        wr(8'hA0, "R9 flag cleared drops request");
        wr(8'h8C, "R9 mismatched enable");

        // R10 / R11 priorities
        wr(8'hA4, "R9 request");
        irq_ack = 1; irq_ret = 1; step("R10 ack beats ret");
        irq_ret = 1; reg_wr = 1; reg_wdata = 8'h24; step("R11 ret beats write");
        irq_ack = 1; reg_wr = 1; reg_wdata = 8'hA4; step("R10 ack beats write");

        // random phase
        for (int i = 0; i < 3000; i++) begin
            reg_wr    = ($urandom % 6) == 0;
            reg_wdata = 8'($urandom);
            port_in   = (($urandom % 4) == 0) ? 8'($urandom) : port_in;
            port_rd   = ($urandom % 5) == 0;
            edge_rise = (($urandom % 50) == 0) ? ~edge_rise : edge_rise;
            tmr_ovf   = ($urandom % 9) == 0;
            irq_ack   = ($urandom % 7) == 0;
            irq_ret   = ($urandom % 7) == 0;
            step("R9 R8 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule